// File: doc/BRIEF.md
# Faulting-Word Access Monitor

This monitor watches a core's retirement trace and its memory bus, and pins one word of the address space as permanently faulting. The word is chosen at run time through the `fault_addr` input. Any byte address inside that word selects it. Whenever a retired instruction was fetched from that word, or a retired load, store or AMO touched it, the monitor checks three things. The core must have trapped. It must have reported the access-fault class that matches the kind of access. It must have left no architectural trace: no register write, no memory write and, for a fetch, no instruction word.

When the bus-fault option is built in, every bus request that addresses the faulting word must be answered in the same cycle with the bus fault line high. Traffic to any other word is not examined.

Each kind of violation sets its own sticky error bit one clock after the offending cycle. The summary flag is high while any bit is set. Both clear only on reset. Trap-handler behaviour after the trap is not examined.

Top module: `fault_word_monitor`

## Requirements
- R1: After reset, `err_flags` is 5'b00000 and `err` is 0.
- R2: A retired instruction whose `ret_pc` lies in the faulting word must have `ret_trap`=1 and `ret_cause`=1. Otherwise bit 0 of `err_flags` (wrong trap class) is set on the next clock edge.
- R3: A retired instruction whose `ret_pc` lies in the faulting word must report `ret_insn`=0. Otherwise bit 1 of `err_flags` is set on the next clock edge.
- R4: A retired load (`ret_mem_op`=1) whose `ret_mem_addr` lies in the faulting word, and whose `ret_pc` does not, must have `ret_trap`=1 and `ret_cause`=5. Otherwise bit 0 is set on the next clock edge.
- R5: A retired store (`ret_mem_op`=2) or AMO (`ret_mem_op`=3) whose `ret_mem_addr` lies in the faulting word, and whose `ret_pc` does not, must have `ret_trap`=1 and `ret_cause`=7. Otherwise bit 0 is set on the next clock edge.
- R6: A faulting data access (as in R4/R5) must report `ret_rd_addr`=0. A nonzero destination index sets bit 2 on the next clock edge.
- R7: A faulting data access (as in R4/R5) must report `ret_mem_wmask`=0. A nonzero mask sets bit 3 on the next clock edge.
- R8: With `CHECK_BUS_FAULT`=1, a cycle with `bus_req`=1, `bus_addr` in the faulting word and `bus_fault`=0 sets bit 4 on the next clock edge.
- R9: Cycles with `ret_valid`=0, retirements touching no byte of the faulting word, and bus requests to other words leave `err_flags` unchanged.
- R10: Error bits are sticky until reset. `err` is 1 exactly when some bit of `err_flags` is 1.
- R11: Word membership ignores the low log2(`WORD_BYTES`) address bits, so every byte offset in the word matches. The adjacent word and addresses that differ in high bits do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_addr | input | ADDR_W | Any byte address inside the faulting word |
| ret_valid | input | 1 | Retirement record valid this cycle |
| ret_trap | input | 1 | Retired instruction trapped |
| ret_pc | input | ADDR_W | Fetch address of the retired instruction |
| ret_insn | input | ILEN | Reported instruction word |
| ret_cause | input | CAUSE_W | Reported exception cause |
| ret_mem_op | input | 2 | Data access kind: 0 none, 1 load, 2 store, 3 AMO |
| ret_mem_addr | input | ADDR_W | Data access address |
| ret_rd_addr | input | REG_W | Destination register index (0 = no write) |
| ret_mem_wmask | input | WORD_BYTES | Reported memory write byte mask |
| bus_req | input | 1 | Bus request this cycle |
| bus_addr | input | ADDR_W | Bus request address |
| bus_fault | input | 1 | Bus fault response for this request |
| err_flags | output | 5 | Sticky violations: 0 class, 1 insn, 2 reg write, 3 mem write, 4 bus fault |
| err | output | 1 | OR of all error bits |

## Verification
The bench sweeps every access kind (fetch, load, store, AMO) over all trap-flag and 16 cause values. Each kind is tried at every byte offset of the faulting word, at the next word, and at an address differing only in a high bit. Together these separate the correct cause for each class from its neighbours and show that the word match is neither too wide nor too narrow. Side-effect fields are varied with the cause bits, so register-write, write-mask and instruction-word violations appear both alone and mixed with class errors. A separate sweep covers bus request, address and fault-line combinations, and a sequence shows that bits accumulate and stay set until reset.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  localparam int unsigned FLAG_N = 5;

  localparam int unsigned FLG_CLASS = 0;
  localparam int unsigned FLG_INSN  = 1;
  localparam int unsigned FLG_RD    = 2;
  localparam int unsigned FLG_WMASK = 3;
  localparam int unsigned FLG_BUS   = 4;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_AMO   = 2'd3
  } acc_kind_e;

  localparam int unsigned CAUSE_FETCH_FAULT = 1;
  localparam int unsigned CAUSE_LOAD_FAULT  = 5;
  localparam int unsigned CAUSE_STORE_FAULT = 7;

  // Cause code owed by an access of the given kind to the faulting word.
  function automatic int unsigned owed_cause(input logic is_fetch, input logic [1:0] kind);
    if (is_fetch)
      return CAUSE_FETCH_FAULT;
    else if (kind == ACC_LOAD)
      return CAUSE_LOAD_FAULT;
    else
      return CAUSE_STORE_FAULT;
  endfunction

  // True when two byte addresses fall in the same word (low bits masked).
  function automatic logic same_word(input logic [63:0] a, input logic [63:0] b,
                                     input logic [63:0] low_mask);
    return ((a ^ b) & ~low_mask) == 64'd0;
  endfunction

endpackage

// File: rtl/fwm_word_match.sv
module fwm_word_match #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              in_word
);
  import fwm_pkg::*;

  localparam int unsigned OFF_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
  localparam logic [63:0] LOW_MASK = (64'd1 << OFF_W) - 64'd1;

  always_comb begin
    in_word = same_word(64'(probe_addr), 64'(word_addr), LOW_MASK);
  end

endmodule

// File: rtl/fwm_rules.sv
module fwm_rules #(
  parameter int unsigned CAUSE_W         = 5,
  parameter int unsigned ILEN            = 32,
  parameter int unsigned REG_W           = 5,
  parameter int unsigned WORD_BYTES      = 4,
  parameter bit          CHECK_BUS_FAULT = 1'b1
) (
  input  logic                       hit_fetch,
  input  logic                       hit_data,
  input  logic                       hit_bus,
  input  logic [1:0]                 mem_op,
  input  logic                       trap,
  input  logic [CAUSE_W-1:0]         cause,
  input  logic [ILEN-1:0]            insn,
  input  logic [REG_W-1:0]           rd_addr,
  input  logic [WORD_BYTES-1:0]      wmask,
  input  logic                       bus_fault,
  output logic [fwm_pkg::FLAG_N-1:0] viol
);
  import fwm_pkg::*;

  logic [CAUSE_W-1:0] cause_owed;
  logic               class_ok;

  always_comb begin
    cause_owed = CAUSE_W'(owed_cause(hit_fetch, mem_op));
    class_ok   = trap && (cause == cause_owed);
  end

  always_comb begin
    viol            = '0;
    viol[FLG_CLASS] = (hit_fetch || hit_data) && !class_ok;
    viol[FLG_INSN]  = hit_fetch && (insn != '0);
    viol[FLG_RD]    = hit_data && (rd_addr != '0);
    viol[FLG_WMASK] = hit_data && (wmask != '0);
    viol[FLG_BUS]   = CHECK_BUS_FAULT ? (hit_bus && !bus_fault) : 1'b0;
  end

endmodule

// File: rtl/fwm_flag_bank.sv
module fwm_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (set_in[i])
        flags[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/fault_word_monitor.sv
module fault_word_monitor #(
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned WORD_BYTES      = 4,
  parameter int unsigned ILEN            = 32,
  parameter int unsigned CAUSE_W         = 5,
  parameter int unsigned REG_W           = 5,
  parameter bit          CHECK_BUS_FAULT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          fault_addr,
  input  logic                       ret_valid,
  input  logic                       ret_trap,
  input  logic [ADDR_W-1:0]          ret_pc,
  input  logic [ILEN-1:0]            ret_insn,
  input  logic [CAUSE_W-1:0]         ret_cause,
  input  logic [1:0]                 ret_mem_op,
  input  logic [ADDR_W-1:0]          ret_mem_addr,
  input  logic [REG_W-1:0]           ret_rd_addr,
  input  logic [WORD_BYTES-1:0]      ret_mem_wmask,
  input  logic                       bus_req,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_fault,
  output logic [fwm_pkg::FLAG_N-1:0] err_flags,
  output logic                       err
);
  import fwm_pkg::*;

  localparam int unsigned PROBES = 3;
  localparam int unsigned P_PC   = 0;
  localparam int unsigned P_MEM  = 1;
  localparam int unsigned P_BUS  = 2;

  logic [ADDR_W-1:0] probe [PROBES];
  logic [PROBES-1:0] in_word;

  assign probe[P_PC]  = ret_pc;
  assign probe[P_MEM] = ret_mem_addr;
  assign probe[P_BUS] = bus_addr;

  for (genvar p = 0; p < PROBES; p++) begin : g_probe
    fwm_word_match #(
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES)
    ) u_match (
      .probe_addr (probe[p]),
      .word_addr  (fault_addr),
      .in_word    (in_word[p])
    );
  end

  // Named events, visible to the bound checker.
  logic hit_fetch;
  logic hit_data;
  logic hit_bus;

  assign hit_fetch = ret_valid && in_word[P_PC];
  assign hit_data  = ret_valid && !in_word[P_PC] && (ret_mem_op != ACC_NONE) && in_word[P_MEM];
  assign hit_bus   = bus_req && in_word[P_BUS];

  logic [FLAG_N-1:0] viol;

  fwm_rules #(
    .CAUSE_W         (CAUSE_W),
    .ILEN            (ILEN),
    .REG_W           (REG_W),
    .WORD_BYTES      (WORD_BYTES),
    .CHECK_BUS_FAULT (CHECK_BUS_FAULT)
  ) u_rules (
    .hit_fetch (hit_fetch),
    .hit_data  (hit_data),
    .hit_bus   (hit_bus),
    .mem_op    (ret_mem_op),
    .trap      (ret_trap),
    .cause     (ret_cause),
    .insn      (ret_insn),
    .rd_addr   (ret_rd_addr),
    .wmask     (ret_mem_wmask),
    .bus_fault (bus_fault),
    .viol      (viol)
  );

  fwm_flag_bank #(
    .N (FLAG_N)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_in (viol),
    .flags  (err_flags)
  );

  assign err = |err_flags;

endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
  parameter int unsigned CAUSE_W         = 5,
  parameter int unsigned ILEN            = 32,
  parameter int unsigned REG_W           = 5,
  parameter int unsigned WORD_BYTES      = 4,
  parameter bit          CHECK_BUS_FAULT = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ret_valid,
  input logic                       ret_trap,
  input logic [CAUSE_W-1:0]         ret_cause,
  input logic [ILEN-1:0]            ret_insn,
  input logic [1:0]                 ret_mem_op,
  input logic [REG_W-1:0]           ret_rd_addr,
  input logic [WORD_BYTES-1:0]      ret_mem_wmask,
  input logic                       bus_req,
  input logic                       bus_fault,
  input logic                       hit_fetch,
  input logic                       hit_data,
  input logic                       hit_bus,
  input logic [fwm_pkg::FLAG_N-1:0] err_flags,
  input logic                       err
);

  AST_FETCH_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fetch && !(ret_trap && ret_cause == CAUSE_W'(1))) |=> err_flags[0]); // R2

  AST_FETCH_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fetch && ret_insn != '0) |=> err_flags[1]); // R3

  AST_LOAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && ret_mem_op == 2'd1 && !(ret_trap && ret_cause == CAUSE_W'(5))) |=> err_flags[0]); // R4

  AST_STORE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && ret_mem_op[1] && !(ret_trap && ret_cause == CAUSE_W'(7))) |=> err_flags[0]); // R5

  AST_DATA_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && ret_rd_addr != '0) |=> err_flags[2]); // R6

  AST_DATA_WMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && ret_mem_wmask != '0) |=> err_flags[3]); // R7

  AST_BUS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (CHECK_BUS_FAULT && hit_bus && !bus_fault) |=> err_flags[4]); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !bus_req) |=> $stable(err_flags)); // R9

  AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(hit_fetch || hit_data || hit_bus)); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && ((err_flags & $past(err_flags)) == $past(err_flags)))); // R10

endmodule

bind fault_word_monitor fwm_checker #(
  .CAUSE_W         (CAUSE_W),
  .ILEN            (ILEN),
  .REG_W           (REG_W),
  .WORD_BYTES      (WORD_BYTES),
  .CHECK_BUS_FAULT (CHECK_BUS_FAULT)
) u_fwm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .ret_valid     (ret_valid),
  .ret_trap      (ret_trap),
  .ret_cause     (ret_cause),
  .ret_insn      (ret_insn),
  .ret_mem_op    (ret_mem_op),
  .ret_rd_addr   (ret_rd_addr),
  .ret_mem_wmask (ret_mem_wmask),
  .bus_req       (bus_req),
  .bus_fault     (bus_fault),
  .hit_fetch     (hit_fetch),
  .hit_data      (hit_data),
  .hit_bus       (hit_bus),
  .err_flags     (err_flags),
  .err           (err)
);

// File: tb/fault_word_monitor_bench.sv
`timescale 1ns/1ps
module fault_word_monitor_bench;

  localparam int unsigned AW = 32;
  localparam logic [31:0] FAULT_BYTE = 32'h0000_1040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fault_addr = FAULT_BYTE;
  logic        ret_valid = 1'b0;
  logic        ret_trap = 1'b0;
  logic [31:0] ret_pc = '0;
  logic [31:0] ret_insn = '0;
  logic [4:0]  ret_cause = '0;
  logic [1:0]  ret_mem_op = '0;
  logic [31:0] ret_mem_addr = '0;
  logic [4:0]  ret_rd_addr = '0;
  logic [3:0]  ret_mem_wmask = '0;
  logic        bus_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_fault = 1'b0;
  logic [4:0]  err_flags;
  logic        err;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fault_word_monitor u_fault_word_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_addr    (fault_addr),
    .ret_valid     (ret_valid),
    .ret_trap      (ret_trap),
    .ret_pc        (ret_pc),
    .ret_insn      (ret_insn),
    .ret_cause     (ret_cause),
    .ret_mem_op    (ret_mem_op),
    .ret_mem_addr  (ret_mem_addr),
    .ret_rd_addr   (ret_rd_addr),
    .ret_mem_wmask (ret_mem_wmask),
    .bus_req       (bus_req),
    .bus_addr      (bus_addr),
    .bus_fault     (bus_fault),
    .err_flags     (err_flags),
    .err           (err)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ret_valid = 0; ret_trap = 0; ret_pc = '0; ret_insn = '0; ret_cause = '0;
    ret_mem_op = '0; ret_mem_addr = '0; ret_rd_addr = '0; ret_mem_wmask = '0;
    bus_req = 0; bus_addr = '0; bus_fault = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // Independent model: word of a byte address is addr / 4.
  function automatic logic in_fault(input logic [31:0] a);
    return (a >> 2) == (FAULT_BYTE >> 2);
  endfunction

  function automatic logic [4:0] expect_ret(input int kind, input logic valid, input logic trap,
                                            input int cause, input logic [31:0] insn,
                                            input int rd, input int wm, input logic [31:0] addr);
    logic [4:0] e;
    int want;
    e = '0;
    if (valid && in_fault(addr)) begin
      if (kind == 0) begin
        want = 1;
        e[0] = !(trap && cause == want);
        e[1] = insn != 0;
      end else begin
        want = (kind == 1) ? 5 : 7;
        e[0] = !(trap && cause == want);
        e[2] = rd != 0;
        e[3] = wm != 0;
      end
    end
    return e;
  endfunction

  // One retirement record, held for a single clock edge; result sampled after it.
  task automatic apply_ret(input int kind, input logic valid, input logic trap, input int cause,
                           input logic [31:0] insn, input int rd, input int wm,
                           input logic [31:0] addr);
    @(negedge clk);
    ret_valid = valid; ret_trap = trap; ret_cause = 5'(cause); ret_insn = insn;
    ret_rd_addr = 5'(rd); ret_mem_wmask = 4'(wm);
    if (kind == 0) begin
      ret_pc = addr; ret_mem_op = 2'd0; ret_mem_addr = '0;
    end else begin
      ret_pc = 32'h0000_0200; ret_mem_op = 2'(kind); ret_mem_addr = addr;
    end
    @(posedge clk);
    #1;
    @(negedge clk);
    idle_inputs();
  endtask

  function automatic string req_for(input int kind);
    case (kind)
      0: return "R2/R3";
      1: return "R4/R6/R7";
      default: return "R5/R6/R7";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] base [3];
    logic [4:0]  exp;
    logic [4:0]  run;
    base[0] = FAULT_BYTE;
    base[1] = FAULT_BYTE + 32'd4;
    base[2] = FAULT_BYTE | 32'h8000_0000;

    idle_inputs();
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset flags", err_flags, 5'b0);
    check("R1 reset err", {4'b0, err}, 5'b0);
    @(negedge clk);
    rst_n = 1;

    // Retirement sweep: kind x cause x trap x address variant x byte offset (R2..R7, R9, R11).
    for (int kind = 0; kind < 4; kind++) begin
      for (int cause = 0; cause < 16; cause++) begin
        for (int trap = 0; trap < 2; trap++) begin
          for (int v = 0; v < 3; v++) begin
            for (int off = 0; off < 4; off++) begin
              logic [31:0] insn;
              int rd;
              int wm;
              insn = cause[0] ? 32'h0000_0013 : 32'h0;
              rd   = cause[1] ? 5 : 0;
              wm   = cause[2] ? (1 << off) : 0;
              do_reset();
              apply_ret(kind, 1'b1, trap[0], cause, insn, rd, wm, base[v] + 32'(off));
              exp = expect_ret(kind, 1'b1, trap[0], cause, insn, rd, wm, base[v] + 32'(off));
              check(v == 0 ? req_for(kind) : "R9/R11 outside word", err_flags, exp);
              check("R10 err is OR", {4'b0, err}, {4'b0, exp != 0});
            end
          end
        end
      end
    end

    // Invalid record with every field wrong at the faulting word (R9).
    for (int kind = 0; kind < 4; kind++) begin
      do_reset();
      apply_ret(kind, 1'b0, 1'b0, 3, 32'hFFFF_FFFF, 7, 15, FAULT_BYTE);
      check("R9 ret_valid low", err_flags, 5'b0);
    end

    // Bus sweep (R8, R9, R11).
    for (int req = 0; req < 2; req++) begin
      for (int v = 0; v < 3; v++) begin
        for (int off = 0; off < 4; off++) begin
          for (int f = 0; f < 2; f++) begin
            do_reset();
            @(negedge clk);
            bus_req = req[0]; bus_addr = base[v] + 32'(off); bus_fault = f[0];
            @(posedge clk);
            #1;
            exp = '0;
            exp[4] = req[0] && in_fault(base[v] + 32'(off)) && !f[0];
            check(v == 0 ? "R8 bus fault" : "R9/R11 bus outside word", err_flags, exp);
          end
        end
      end
    end

    // Sticky accumulation and clear by reset (R10, R1).
    do_reset();
    apply_ret(1, 1'b1, 1'b1, 5, 32'h0, 9, 0, FAULT_BYTE);
    run = 5'b00100;
    check("R10 first bit", err_flags, run);
    repeat (3) @(posedge clk);
    #1;
    check("R10 held idle", err_flags, run);
    apply_ret(2, 1'b1, 1'b1, 7, 32'h0, 0, 4'b1000, FAULT_BYTE + 32'd3);
    run = 5'b01100;
    check("R10 accumulate", err_flags, run);
    apply_ret(3, 1'b1, 1'b1, 7, 32'h0, 0, 0, FAULT_BYTE);
    check("R10 clean AMO keeps bits", err_flags, run);
    check("R10 err high", {4'b0, err}, 5'b1);
    do_reset();
    #1;
    check("R1 reset clears", err_flags, 5'b0);

    // Simultaneous fetch hit and unanswered bus request (R2, R8).
    @(negedge clk);
    ret_valid = 1; ret_trap = 0; ret_cause = 5'd1; ret_pc = FAULT_BYTE; ret_insn = '0;
    bus_req = 1; bus_addr = FAULT_BYTE; bus_fault = 0;
    @(posedge clk);
    #1;
    check("R2/R8 combined", err_flags, 5'b10001);
    @(negedge clk);
    idle_inputs();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule